// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block is the digital control for an 8-bit, 8-input successive-approximation analog-to-digital converter. A start command latches a 3-bit input select and a clock-rate choice. The block then drives the analog multiplexer select and a sample-enable for a fixed sampling window. After that it presents trial codes to an external DAC and reads one comparator bit back for each trial. The converter, DAC and multiplexer sit outside the block.

The conversion timebase runs at either the system clock rate or half of it. Sampling lasts 12 timebase ticks. The next 144 ticks form eight decision slots of 18 ticks each, resolved from the most significant bit down. A 4-tick settle period closes the conversion, so one conversion takes 160 ticks. At that point the result register loads, a done flag rises and a single-cycle interrupt pulse fires.

Top module: `sar_adc_seq`

## Requirements
- R1: With the comparator reporting 1 when the analog input is at or above the trial code, the result equals the input code. An input at zero gives 00h, and an input above the top code gives FFh.
- R2: With `clk_half_i` = 0 at start, the result, `done_o` and `irq_o` update 160 system clock cycles after the clock edge that accepts the start.
- R3: With `clk_half_i` = 1 at start, the timebase ticks on every second system cycle, and the conversion takes 320 system cycles. The rate choice is latched when the start is accepted.
- R4: `sample_en_o` is high for exactly 12 timebase ticks right after the start: 12 system cycles at full rate, 24 at half rate. It is high only while the block is busy.
- R5: Trial codes are resolved MSB first. The first nonzero trial code is 80h. The trial code changes only on a timebase tick.
- R6: A start request while a conversion runs is ignored. The running conversion keeps its input select, its timing and its result.
- R7: `mux_sel_o` takes the value of `chan_i` at the accepted start and holds it for the whole conversion.
- R8: `irq_o` is a one-cycle pulse, raised in the same cycle that `done_o` sets and `result_o` updates. `result_o` changes only in that cycle.
- R9: `done_o` clears in the cycle after the next accepted start.
- R10: After reset, `busy_o`, `done_o`, `irq_o`, `sample_en_o` and `result_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start request; accepted only while idle |
| chan_i | input | 3 | Analog input select, latched at start |
| clk_half_i | input | 1 | 1: timebase is half the system clock; 0: full rate |
| cmp_i | input | 1 | Comparator: 1 when the input is at or above the trial code |
| mux_sel_o | output | 3 | Analog multiplexer select |
| sample_en_o | output | 1 | Sample-and-hold enable |
| dac_code_o | output | 8 | Trial code to the DAC |
| busy_o | output | 1 | Conversion in progress |
| result_o | output | 8 | Last conversion result |
| done_o | output | 1 | Result valid since the last start |
| irq_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume the comparator output depends only on the held analog input and the current trial code, and that it settles within the same cycle the code changes. The bench models the comparator as a combinational threshold against a stimulus value. It changes that value only while the block is idle. It drives start pulses only at negative clock edges, and it issues extra starts during a conversion on purpose to test R6.

// File: rtl/sar_pkg.sv
// Shared types for the successive-approximation sequencer.
package sar_pkg;

    // Phase of one conversion.
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SAMPLE = 2'd1,
        PH_CONV   = 2'd2,
        PH_SETTLE = 2'd3
    } sar_phase_t;

endpackage

// File: rtl/sar_tick_gen.sv
// Conversion timebase enable.
// Produces one tick per timebase cycle: every system cycle at full rate,
// every second cycle at half rate. The rate is latched when a start is
// accepted, and the phase restarts so the first half-rate tick lands on the
// second edge after the start. Assumes launch_i is a single-cycle pulse.
module sar_tick_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic launch_i,
    input  logic run_i,
    input  logic half_i,
    output logic tick_o
);

    logic half_q;
    logic ph_q;

    // Latch the rate at launch and toggle the phase while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q <= 1'b0;
            ph_q   <= 1'b0;
        end else if (launch_i) begin
            half_q <= half_i;
            ph_q   <= 1'b0;
        end else if (run_i) begin
            ph_q   <= ~ph_q;
        end
    end

    // Tick on every cycle at full rate, on odd phase at half rate.
    always_comb tick_o = half_q ? ph_q : 1'b1;

    // R3: at half rate no two consecutive ticks while running.
    a_r3_half_rate_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (half_q && run_i && !launch_i && tick_o) |=> !tick_o);

endmodule

// File: rtl/sar_seq_fsm.sv
// Phase sequencer.
// Steps through sampling, per-bit decision slots and the settle period,
// counting timebase ticks. It emits single-cycle strobes at entry to the
// decision phase, at each slot end and at completion. Assumes tick_i comes
// from sar_tick_gen and that SAMPLE_CYC and the slot length are nonzero.
module sar_seq_fsm
    import sar_pkg::*;
#(
    parameter int RES_BITS   = 8,
    parameter int SAMPLE_CYC = 12,
    parameter int TOTAL_CYC  = 160
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic                        tick_i,
    output logic                        launch_o,
    output logic                        busy_o,
    output logic                        sample_o,
    output logic                        enter_conv_o,
    output logic                        decide_o,
    output logic                        finish_o,
    output logic [$clog2(RES_BITS)-1:0] idx_o
);

    localparam int SLOT_CYC    = (TOTAL_CYC - SAMPLE_CYC) / RES_BITS;
    localparam int SETTLE_CYC  = TOTAL_CYC - SAMPLE_CYC - SLOT_CYC * RES_BITS;
    localparam int CNT_W       = $clog2(TOTAL_CYC + 1);
    localparam int IDX_W       = $clog2(RES_BITS);
    localparam logic [CNT_W-1:0] SAMPLE_LAST = CNT_W'(SAMPLE_CYC - 1);
    localparam logic [CNT_W-1:0] SLOT_LAST   = CNT_W'(SLOT_CYC - 1);
    localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'((SETTLE_CYC == 0) ? 0 : SETTLE_CYC - 1);
    localparam logic [IDX_W-1:0] IDX_TOP     = IDX_W'(RES_BITS - 1);

    sar_phase_t       phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] idx_q;
    logic             last_decide;

    // Strobes decoded from phase, tick and counter.
    always_comb begin
        launch_o     = (phase_q == PH_IDLE) && start_i;
        busy_o       = (phase_q != PH_IDLE);
        sample_o     = (phase_q == PH_SAMPLE);
        enter_conv_o = (phase_q == PH_SAMPLE) && tick_i && (cnt_q == SAMPLE_LAST);
        decide_o     = (phase_q == PH_CONV) && tick_i && (cnt_q == SLOT_LAST);
        last_decide  = decide_o && (idx_q == '0);
        finish_o     = ((phase_q == PH_SETTLE) && tick_i && (cnt_q == SETTLE_LAST))
                    || ((SETTLE_CYC == 0) && last_decide);
        idx_o        = idx_q;
    end

    // Phase, tick counter and bit index update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (start_i) begin
                        phase_q <= PH_SAMPLE;
                        cnt_q   <= '0;
                    end
                end
                PH_SAMPLE: begin
                    if (tick_i) begin
                        if (cnt_q == SAMPLE_LAST) begin
                            phase_q <= PH_CONV;
                            cnt_q   <= '0;
                            idx_q   <= IDX_TOP;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                PH_CONV: begin
                    if (tick_i) begin
                        if (cnt_q == SLOT_LAST) begin
                            cnt_q <= '0;
                            if (idx_q == '0) begin
                                phase_q <= (SETTLE_CYC == 0) ? PH_IDLE : PH_SETTLE;
                            end else begin
                                idx_q <= idx_q - 1'b1;
                            end
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                default: begin
                    if (tick_i) begin
                        if (cnt_q == SETTLE_LAST) begin
                            phase_q <= PH_IDLE;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    // R2: slot counter never passes the slot length during decisions.
    a_r2_slot_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_CONV) |-> (cnt_q <= SLOT_LAST));

    // R4: sampling never follows directly on a decision slot.
    a_r4_sample_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sample_o) |-> $past(phase_q == PH_IDLE));

endmodule

// File: rtl/sar_code_reg.sv
// Trial code and result registers.
// Clears the trial code at launch and sets the MSB when decisions begin. At
// each slot end it keeps or clears the current bit from the comparator and
// sets the next lower bit. The result loads from the resolved code at finish.
// Assumes decide_i and finish_i come from sar_seq_fsm.
module sar_code_reg #(
    parameter int RES_BITS = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        launch_i,
    input  logic                        enter_conv_i,
    input  logic                        decide_i,
    input  logic                        finish_i,
    input  logic                        cmp_i,
    input  logic [$clog2(RES_BITS)-1:0] idx_i,
    output logic [RES_BITS-1:0]         code_o,
    output logic [RES_BITS-1:0]         result_o
);

    logic [RES_BITS-1:0] code_q;
    logic [RES_BITS-1:0] code_d;
    logic [RES_BITS-1:0] result_q;

    // Next trial code: apply the decision for the current bit.
    always_comb begin
        code_d = code_q;
        if (decide_i) begin
            if (!cmp_i) code_d[idx_i] = 1'b0;
            if (idx_i != '0) code_d[idx_i - 1'b1] = 1'b1;
        end
    end

    // Trial code register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
        end else if (launch_i) begin
            code_q <= '0;
        end else if (enter_conv_i) begin
            code_q <= {1'b1, {(RES_BITS-1){1'b0}}};
        end else begin
            code_q <= code_d;
        end
    end

    // Result register, loaded once per conversion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
        end else if (finish_i) begin
            result_q <= code_d;
        end
    end

    assign code_o   = code_q;
    assign result_o = result_q;

    // R5: decisions begin at the MSB.
    a_r5_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
        enter_conv_i |=> (code_q == {1'b1, {(RES_BITS-1){1'b0}}}));

endmodule

// File: rtl/sar_adc_seq.sv
// Successive-approximation converter sequencer, top level.
// Accepts a start while idle and latches the input select and rate. It runs
// the sample, decision and settle phases, then loads the result, sets done
// and pulses the interrupt. Assumes cmp_i reflects the current dac_code_o
// within the same cycle.
module sar_adc_seq #(
    parameter int RES_BITS   = 8,
    parameter int CHAN_BITS  = 3,
    parameter int SAMPLE_CYC = 12,
    parameter int TOTAL_CYC  = 160
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [CHAN_BITS-1:0] chan_i,
    input  logic                 clk_half_i,
    input  logic                 cmp_i,
    output logic [CHAN_BITS-1:0] mux_sel_o,
    output logic                 sample_en_o,
    output logic [RES_BITS-1:0]  dac_code_o,
    output logic                 busy_o,
    output logic [RES_BITS-1:0]  result_o,
    output logic                 done_o,
    output logic                 irq_o
);

    localparam int IDX_W = $clog2(RES_BITS);

    logic             tick;
    logic             launch;
    logic             busy;
    logic             sample;
    logic             enter_conv;
    logic             decide;
    logic             finish;
    logic [IDX_W-1:0] idx;
    logic [CHAN_BITS-1:0] chan_q;
    logic             done_q;
    logic             irq_q;

    sar_tick_gen u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch_i (launch),
        .run_i    (busy),
        .half_i   (clk_half_i),
        .tick_o   (tick)
    );

    sar_seq_fsm #(
        .RES_BITS   (RES_BITS),
        .SAMPLE_CYC (SAMPLE_CYC),
        .TOTAL_CYC  (TOTAL_CYC)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .tick_i       (tick),
        .launch_o     (launch),
        .busy_o       (busy),
        .sample_o     (sample),
        .enter_conv_o (enter_conv),
        .decide_o     (decide),
        .finish_o     (finish),
        .idx_o        (idx)
    );

    sar_code_reg #(
        .RES_BITS (RES_BITS)
    ) u_code (
        .clk          (clk),
        .rst_n        (rst_n),
        .launch_i     (launch),
        .enter_conv_i (enter_conv),
        .decide_i     (decide),
        .finish_i     (finish),
        .cmp_i        (cmp_i),
        .idx_i        (idx),
        .code_o       (dac_code_o),
        .result_o     (result_o)
    );

    // Latch the input select at an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)      chan_q <= '0;
        else if (launch) chan_q <= chan_i;
    end

    // Done flag and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= finish;
            if (launch)      done_q <= 1'b0;
            else if (finish) done_q <= 1'b1;
        end
    end

    assign mux_sel_o   = chan_q;
    assign sample_en_o = sample;
    assign busy_o      = busy;
    assign done_o      = done_q;
    assign irq_o       = irq_q;

    // R8: the interrupt lasts one cycle.
    a_r8_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    // R8: the interrupt coincides with the done flag.
    a_r8_irq_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> done_o);

    // R8: the result moves only together with the interrupt.
    a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result_o) |-> irq_o);

    // R4: sampling happens only inside a conversion.
    a_r4_sample_busy: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en_o |-> busy_o);

    // R7: select held for the whole conversion (also covers R6).
    a_r7_select_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(mux_sel_o));

    // R5: trial code changes only on a timebase tick.
    a_r5_code_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !tick) |=> $stable(dac_code_o));

endmodule

// File: tb/sar_adc_seq_tb.sv
// Scoreboard bench: the driver queues expected results, the monitor checks them.
module sar_adc_seq_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [2:0] chan_i = '0;
    logic       clk_half_i = 1'b0;
    logic       cmp_i;
    logic [2:0] mux_sel_o;
    logic       sample_en_o;
    logic [7:0] dac_code_o;
    logic       busy_o;
    logic [7:0] result_o;
    logic       done_o;
    logic       irq_o;

    logic [8:0] vin = '0;
    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    int q_res[$];
    int q_lat[$];
    int q_samp[$];
    int q_start[$];

    int samp_cnt = 0;
    int mux_bad = 0;
    int first_code = 0;
    bit seen_code = 0;
    logic [2:0] cur_ch = '0;
    int n_done = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Comparator model: 1 when the stimulus is at or above the trial code.
    assign cmp_i = (vin >= {1'b0, dac_code_o});

    sar_adc_seq u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .chan_i      (chan_i),
        .clk_half_i  (clk_half_i),
        .cmp_i       (cmp_i),
        .mux_sel_o   (mux_sel_o),
        .sample_en_o (sample_en_o),
        .dac_code_o  (dac_code_o),
        .busy_o      (busy_o),
        .result_o    (result_o),
        .done_o      (done_o),
        .irq_o       (irq_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Driver: queue the expectation, pulse start, optionally retry while busy.
    task automatic run_conv(input int v, input int ch, input bit half, input bit retry);
        vin        = 9'(v);
        cur_ch     = 3'(ch);
        samp_cnt   = 0;
        mux_bad    = 0;
        seen_code  = 0;
        first_code = 0;
        q_res.push_back(v > 255 ? 255 : v);
        q_lat.push_back(half ? 320 : 160);
        q_samp.push_back(half ? 24 : 12);
        q_start.push_back(cyc);
        chan_i     = 3'(ch);
        clk_half_i = half;
        start_i    = 1'b1;
        @(negedge clk);
        start_i    = 1'b0;
        chan_i     = 3'(ch + 3);
        clk_half_i = ~half;
        // R9: done cleared after the accepted start.
        chk(done_o == 1'b0 && busy_o == 1'b1, "R9", int'(done_o), 0);
        if (retry) begin
            repeat (50) @(negedge clk);
            chan_i  = 3'(ch + 5);
            start_i = 1'b1;          // R6: must be ignored
            @(negedge clk);
            start_i = 1'b0;
            repeat (100) @(negedge clk);
            start_i = 1'b1;          // R6: second ignored request
            @(negedge clk);
            start_i = 1'b0;
        end
        do @(negedge clk); while (!irq_o);
        @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: track activity during a conversion and score on the interrupt.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && busy_o) begin
                if (sample_en_o) samp_cnt++;
                if (mux_sel_o != cur_ch) mux_bad++;
                if (!seen_code && dac_code_o != 8'h00) begin
                    seen_code  = 1;
                    first_code = int'(dac_code_o);
                end
            end
            if (rst_n && irq_o) begin
                int e_res, e_lat, e_samp, s, lat;
                e_res  = q_res.pop_front();
                e_lat  = q_lat.pop_front();
                e_samp = q_samp.pop_front();
                s      = q_start.pop_front();
                lat    = cyc - s - 1;
                chk(int'(result_o) == e_res, "R1", int'(result_o), e_res);
                chk(lat == e_lat, (e_lat == 320) ? "R3" : "R2", lat, e_lat);
                chk(samp_cnt == e_samp, "R4", samp_cnt, e_samp);
                chk(first_code == 8'h80, "R5", first_code, 128);
                chk(mux_bad == 0, "R7", mux_bad, 0);
                chk(done_o == 1'b1, "R8", int'(done_o), 1);
                @(negedge clk);
                chk(irq_o == 1'b0 && done_o == 1'b1, "R8", int'(irq_o), 0);
                n_done++;
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Stimulus sequence.
    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state.
        chk(busy_o == 0 && done_o == 0 && irq_o == 0 && sample_en_o == 0,
            "R10", int'({busy_o, done_o, irq_o, sample_en_o}), 0);
        chk(result_o == 8'h00, "R10", int'(result_o), 0);

        run_conv(8'h00, 0, 1'b0, 1'b0);   // R1 bottom code
        run_conv(8'hFF, 1, 1'b0, 1'b0);   // R1 top code
        run_conv(300,   2, 1'b0, 1'b0);   // R1 above range clamps to FFh
        run_conv(8'h80, 3, 1'b0, 1'b0);
        run_conv(8'h7F, 4, 1'b0, 1'b0);
        run_conv(8'h55, 5, 1'b0, 1'b0);
        run_conv(8'hAA, 6, 1'b1, 1'b0);   // R3 half rate
        run_conv(8'h3C, 7, 1'b1, 1'b0);   // R3 half rate
        run_conv(8'hC3, 2, 1'b0, 1'b1);   // R6 start while busy
        run_conv(8'h01, 5, 1'b1, 1'b1);   // R6 at half rate

        chk(n_done == 10, "R6", n_done, 10);
        chk(q_res.size() == 0, "R2", q_res.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule